// File: doc/BRIEF.md
# Write-Busy Status Readback Generator

This block is the device-side status logic of a byte-wide nonvolatile memory whose write and erase cycles run on an internal timer. The host loads a byte with chip-enable and write-enable held low and output-enable held high. The load ends when either enable returns high, whichever comes first. That edge starts a busy interval whose length is a parameter in clock cycles.

While the interval runs, every read returns a status byte instead of array data. In write mode, the top bit of the status byte is the inverse of the top bit of the last loaded byte. The bit below it flips once per read access. An erase cycle is flagged by `erase_sel` during the load. In that mode only the alternating bit carries meaning, and all other status bits read as zero.

When the interval expires, a one-cycle `done` pulse is raised and reads pass the array data through again. All strobes are active low and are taken as synchronous to `clk`. Read data is registered, so it appears one clock after the read condition is sampled.

Top module: `wbs_status_top`

## Requirements
- R1: After reset, `busy`, `done` and `dout` are all 0.
- R2: A write access exists while `ce_n`=0, `we_n`=0 and `oe_n`=1. The first clock at which this condition ends, through `ce_n` or `we_n` rising while idle, starts the busy interval. `busy` reads 1 one clock later and stays 1 for exactly BUSY_CYCLES clocks.
- R3: `done` is 1 for exactly one clock, the first clock in which `busy` is 0 again after an interval.
- R4: Write accesses made while `busy`=1 are ignored. They neither restart nor lengthen the interval, and they do not replace the captured byte that the status reflects.
- R5: In write mode, a read made while busy returns bit 7 equal to the inverse of bit 7 of the last loaded byte. Bits 5..0 equal bits 5..0 of that byte.
- R6: A read access begins at the clock where `ce_n`=0 and `oe_n`=0 first hold together. While busy, bit 6 flips once per read access, and the first read after the interval starts returns 1. Holding one read over several clocks does not change bit 6.
- R7: When `erase_sel`=1 during the load, reads while busy return 0 on bit 7 and bits 5..0, while bit 6 alternates as in R6.
- R8: When not busy, a read returns `mem_rdata` as sampled one clock earlier, and repeated reads show no alternation.
- R9: When no read access is present (`ce_n`=1 or `oe_n`=1), `dout` is 0 on the following clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| erase_sel | input | 1 | 1 marks the current load as an erase |
| din | input | DATA_W | Byte being loaded |
| mem_rdata | input | DATA_W | Array data for reads when idle |
| dout | output | DATA_W | Registered read data or status byte |
| busy | output | 1 | Internal cycle in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Loads are ended by write-enable in one test and by chip-enable in another, which separates the two start paths. Loaded bytes with bit 7 set and with bit 7 clear show that polling inverts the bit rather than forcing a value. Alternating short reads are contrasted with one read held over several clocks, so a toggle driven by the level of the read condition is told apart from one driven by its edge. A second load inside a running interval, followed by a status read and an exact duration count, separates an ignored write from one that restarts the timer or recaptures data. The erase test and the idle pass-through reads cover the two other read sources.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
    typedef enum logic {
        OP_WRITE = 1'b0,
        OP_ERASE = 1'b1
    } wbs_op_e;
endpackage

// File: rtl/wbs_strobe_edges.sv
module wbs_strobe_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    output logic wr_act,
    output logic wr_end,
    output logic rd_act,
    output logic rd_start
);
    typedef struct packed {
        logic wr_prev;
        logic rd_prev;
    } edge_t;

    edge_t edge_d, edge_q;

    always_comb begin
        wr_act         = !ce_n && !we_n && oe_n;
        rd_act         = !ce_n && !oe_n;
        wr_end         = edge_q.wr_prev && !wr_act;
        rd_start       = rd_act && !edge_q.rd_prev;
        edge_d         = edge_q;
        edge_d.wr_prev = wr_act;
        edge_d.rd_prev = rd_act;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) edge_q <= '0;
        else        edge_q <= edge_d;
    end
endmodule

// File: rtl/wbs_busy_timer.sv
module wbs_busy_timer #(
    parameter int BUSY_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic accept,
    output logic busy,
    output logic done
);
    localparam int CNT_W = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d      = tmr_q;
        tmr_d.done = 1'b0;
        accept     = start && !tmr_q.busy;
        if (!tmr_q.busy) begin
            if (start) begin
                tmr_d.busy = 1'b1;
                tmr_d.cnt  = CNT_W'(BUSY_CYCLES - 1);
            end
        end else if (tmr_q.cnt == '0) begin
            tmr_d.busy = 1'b0;
            tmr_d.done = 1'b1;
        end else begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy = tmr_q.busy;
    assign done = tmr_q.done;

    AST_BUSY_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.busy && tmr_q.cnt != '0) |=> (tmr_q.busy && tmr_q.cnt == $past(tmr_q.cnt) - 1'b1)); // R4
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.done |-> (!tmr_q.busy && $past(tmr_q.busy))); // R3
endmodule

// File: rtl/wbs_status_gen.sv
module wbs_status_gen
    import wbs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_act,
    input  logic              rd_act,
    input  logic              rd_start,
    input  logic              accept,
    input  logic              busy,
    input  logic              erase_sel,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] dout
);
    localparam int POLL_BIT = DATA_W - 1;
    localparam int TOG_BIT  = DATA_W - 2;

    typedef struct packed {
        logic [DATA_W-1:0] last;
        wbs_op_e           op;
        logic              tog;
        logic [DATA_W-1:0] dout;
    } st_t;

    st_t st_d, st_q;
    logic [DATA_W-1:0] status_byte;

    always_comb begin
        st_d = st_q;
        if (wr_act && !busy) begin
            st_d.last = din;
            st_d.op   = erase_sel ? OP_ERASE : OP_WRITE;
        end
        if (accept)                st_d.tog = 1'b0;
        else if (busy && rd_start) st_d.tog = ~st_q.tog;

        for (int i = 0; i < DATA_W; i++) begin
            if (i == TOG_BIT)                status_byte[i] = st_d.tog;
            else if (st_q.op == OP_ERASE)    status_byte[i] = 1'b0;
            else if (i == POLL_BIT)          status_byte[i] = ~st_q.last[i];
            else                             status_byte[i] = st_q.last[i];
        end

        if (!rd_act)   st_d.dout = '0;
        else if (busy) st_d.dout = status_byte;
        else           st_d.dout = mem_rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.dout;

    AST_POLL_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_act && st_q.op == OP_WRITE) |=> (dout[POLL_BIT] == ~$past(st_q.last[POLL_BIT]))); // R5
    AST_ERASE_POLL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_act && st_q.op == OP_ERASE) |=> (dout[POLL_BIT] == 1'b0)); // R7
    AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd_start) |=> $stable(st_q.tog)); // R6
    AST_IDLE_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rd_act) |=> (dout == $past(mem_rdata))); // R8
    AST_NO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_act |=> (dout == '0)); // R9
endmodule

// File: rtl/wbs_status_top.sv
module wbs_status_top #(
    parameter int DATA_W      = 8,
    parameter int BUSY_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              erase_sel,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] dout,
    output logic              busy,
    output logic              done
);
    logic wr_act, wr_end, rd_act, rd_start, accept;

    wbs_strobe_edges u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .wr_act   (wr_act),
        .wr_end   (wr_end),
        .rd_act   (rd_act),
        .rd_start (rd_start)
    );

    wbs_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (wr_end),
        .accept (accept),
        .busy   (busy),
        .done   (done)
    );

    wbs_status_gen #(.DATA_W(DATA_W)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_act    (wr_act),
        .rd_act    (rd_act),
        .rd_start  (rd_start),
        .accept    (accept),
        .busy      (busy),
        .erase_sel (erase_sel),
        .din       (din),
        .mem_rdata (mem_rdata),
        .dout      (dout)
    );

    AST_START_ON_WRITE_END: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_end && !busy) |=> busy); // R2
endmodule

// File: tb/sim_wbs_status_top.sv
module sim_wbs_status_top;
    localparam int N = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, erase_sel = 1'b0;
    logic [7:0] din = 8'h00, mem_rdata = 8'h00;
    logic [7:0] dout;
    logic       busy, done;
    int         errs = 0, chks = 0, cyc = 0;
    bit         finished = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wbs_status_top #(.DATA_W(8), .BUSY_CYCLES(N)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .erase_sel(erase_sel), .din(din), .mem_rdata(mem_rdata),
        .dout(dout), .busy(busy), .done(done)
    );

    task automatic check(input string req, input int act, input int exp);
        chks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] d, input logic er, input bit end_by_ce);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; din = d; erase_sel = er;
        @(negedge clk);
        if (end_by_ce) ce_n = 1'b1; else we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; erase_sel = 1'b0;
    endtask

    task automatic do_read(output logic [7:0] v);
        ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        v = dout;
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 dout", int'(dout), 0);
    endtask

    task automatic t_idle_read();
        logic [7:0] v;
        mem_rdata = 8'h5A;
        do_read(v);
        check("R8 idle read", int'(v), 8'h5A);
        check("R9 dout after read ends", int'(dout), 0);
        do_read(v);
        check("R8 no toggle when idle", int'(v), 8'h5A);
    endtask

    task automatic t_duration_we();
        int t0;
        do_write(8'h83, 1'b0, 1'b0);
        check("R2 busy after WE rise", int'(busy), 1);
        t0 = cyc;
        while (busy) begin
            check("R3 no done while busy", int'(done), 0);
            @(negedge clk);
        end
        check("R2 busy length", cyc - t0, N);
        check("R3 done pulse", int'(done), 1);
        @(negedge clk);
        check("R3 done one cycle", int'(done), 0);
    endtask

    task automatic t_poll_toggle();
        logic [7:0] v, h;
        do_write(8'h83, 1'b0, 1'b1);
        check("R2 busy after CE rise", int'(busy), 1);
        do_read(v);
        check("R5 bit7 inverted", int'(v[7]), 0);
        check("R5 low bits", int'(v[5:0]), 8'h03);
        check("R6 first toggle is 1", int'(v[6]), 1);
        do_read(v);
        check("R6 second toggle", int'(v[6]), 0);
        do_read(v);
        check("R6 third toggle", int'(v[6]), 1);
        ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk); h = dout;
        check("R6 held read first", int'(h[6]), 0);
        @(negedge clk);
        check("R6 held read stable", int'(dout[6]), 0);
        @(negedge clk);
        check("R6 held read stable 2", int'(dout[6]), 0);
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        check("R9 dout zero when idle strobes", int'(dout), 0);
        wait_idle();
        mem_rdata = 8'hC3;
        do_read(v);
        check("R8 true data after cycle", int'(v), 8'hC3);
        do_read(v);
        check("R8 toggle stopped", int'(v), 8'hC3);
    endtask

    task automatic t_poll_clear();
        logic [7:0] v;
        do_write(8'h11, 1'b0, 1'b0);
        do_read(v);
        check("R5 bit7 reads 1 for 0 loaded", int'(v[7]), 1);
        check("R5 low bits 11", int'(v[5:0]), 8'h11);
        wait_idle();
    endtask

    task automatic t_ignore();
        logic [7:0] v;
        int t0;
        do_write(8'hF0, 1'b0, 1'b0);
        t0 = cyc;
        repeat (3) @(negedge clk);
        do_write(8'h00, 1'b0, 1'b1);
        do_read(v);
        check("R4 byte kept bit7", int'(v[7]), 0);
        check("R4 byte kept low", int'(v[5:0]), 8'h30);
        check("R4 toggle not reset", int'(v[6]), 1);
        while (busy) @(negedge clk);
        check("R4 no restart", cyc - t0, N);
        check("R4 done at original end", int'(done), 1);
        @(negedge clk);
    endtask

    task automatic t_erase();
        logic [7:0] v;
        do_write(8'h7F, 1'b1, 1'b0);
        do_read(v);
        check("R7 erase bit7", int'(v[7]), 0);
        check("R7 erase low bits", int'(v[5:0]), 0);
        check("R7 erase toggle 1", int'(v[6]), 1);
        do_read(v);
        check("R7 erase toggle 0", int'(v[6]), 0);
        wait_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_read();
        t_duration_we();
        t_poll_toggle();
        t_poll_clear();
        t_ignore();
        t_erase();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, chks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            chks++;
            errs++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, chks);
            $finish;
        end
    end
endmodule